// File: doc/BRIEF.md
# Serially Loaded Address Counter

This block produces a 24-bit address for a byte-wide static memory. A host sends the start address one bit at a time on a serial data line. Each rising edge of a shift clock captures one bit, most significant bit first. A latch strobe then moves the assembled word into a holding register. A separate active-low load strobe then copies the held word into an up/down counter, and the counter drives the address bus.

During a burst, the host steps the counter with active-low up or down pulses between bytes, so it does not have to resend the address. Every host strobe is asynchronous to the system clock. The block synchronises each strobe through two flip-flops and acts only on the detected edge. One host pulse therefore causes exactly one action, however long the pulse is. An action shows on `addr_o` after the third rising clock edge that follows the strobe transition.

Top module: `ser_addr_ctr`

## Requirements
- R1: While reset is asserted, and after it is released with the strobes idle, `addr_o` is 0. The shift register and the holding register also clear to 0.
- R2: Each rising edge of `sclk_i` shifts in the level of `sdata_i`, most significant bit first. After 24 edges, bit 23 of the shift register holds the first bit sent.
- R3: A rising edge of `latch_i` copies the shift register into the holding register. `addr_o` does not change until a load happens.
- R4: A falling edge of `load_ni` copies the holding register into the counter. `addr_o` shows the new value after the third rising clock edge that follows the transition.
- R5: A falling edge of `up_ni` increments the counter by one. A pulse held low for many cycles still increments only once.
- R6: A falling edge of `down_ni` decrements the counter by one.
- R7: An increment from 0xFFFFFF gives 0, and a decrement from 0 gives 0xFFFFFF.
- R8: When a load edge and a step edge are detected in the same cycle, the load wins and the step is discarded.
- R9: When up and down edges are detected in the same cycle with no load, the counter keeps its value.
- R10: Shifting in a new word without a latch edge leaves the holding register unchanged. A later load gives the previously latched word.
- R11: When more than 24 bits are shifted in before a latch, only the last 24 bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial address bit, sampled on a rising `sclk_i` |
| sclk_i | input | 1 | Shift clock strobe, idles low |
| latch_i | input | 1 | Latch strobe, idles low, acts on its rising edge |
| load_ni | input | 1 | Load strobe, idles high, acts on its falling edge |
| up_ni | input | 1 | Increment strobe, idles high, acts on its falling edge |
| down_ni | input | 1 | Decrement strobe, idles high, acts on its falling edge |
| addr_o | output | 24 | Counter value driving the memory address bus |

## Verification
The hardest cases to reach are the same-cycle collisions of R8 and R9. Both strobes must reach their edge detectors in the same system clock. The bench gets there by driving both strobes low on the same falling clock edge, so both cross the synchroniser in lockstep. Stale-word cases are also hard to see from the ports, because the holding register is visible only through a later load. The bench therefore shifts a word without latching it, and also shifts an overlong word, then issues a load and compares the address. A behavioural reference model replays the three-cycle strobe latency and compares `addr_o` on every clock.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;
  localparam int unsigned N_STROBE  = 5;
  localparam int unsigned IDX_SCLK  = 0;
  localparam int unsigned IDX_LATCH = 1;
  localparam int unsigned IDX_LOAD  = 2;
  localparam int unsigned IDX_UP    = 3;
  localparam int unsigned IDX_DN    = 4;
  // 1 marks an active-low strobe (idles high, acts on falling edge)
  localparam logic [N_STROBE-1:0] STROBE_ACT_LOW = 5'b11100;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } ctr_op_e;

  // load beats any step; opposing steps cancel
  function automatic ctr_op_e decode_op(logic load, logic up, logic dn);
    if (load)           return OP_LOAD;
    else if (up && !dn) return OP_INC;
    else if (dn && !up) return OP_DEC;
    else                return OP_HOLD;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned            N       = 5,
  parameter int unsigned            STAGES  = 2,
  parameter logic [N-1:0]           ACT_LOW = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] pulse_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [N-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= ACT_LOW;
    end else begin
      stg_q[0] <= raw_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_edge
    if (ACT_LOW[b]) begin : g_fall
      assign pulse_o[b] = ~stg_q[STAGES-1][b] & stg_q[STAGES][b];
    end else begin : g_rise
      assign pulse_o[b] = stg_q[STAGES-1][b] & ~stg_q[STAGES][b];
    end
  end
endmodule

// File: rtl/ser_shift_hold.sv
module ser_shift_hold #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              shift_p_i,
  input  logic              latch_p_i,
  output logic [ADDR_W-1:0] shift_o,
  output logic [ADDR_W-1:0] hold_o
);
  // data takes the same number of stages as the shift strobe so they align
  logic [STAGES-1:0] dsync_q;
  logic [ADDR_W-1:0] shift_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dsync_q <= '0;
    else         dsync_q <= {dsync_q[STAGES-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shift_q <= '0;
    else if (shift_p_i) shift_q <= {shift_q[ADDR_W-2:0], dsync_q[STAGES-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (latch_p_i) hold_q <= shift_q;
  end

  assign shift_o = shift_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/addr_updown.sv
module addr_updown
  import addr_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_p_i,
  input  logic              up_p_i,
  input  logic              dn_p_i,
  input  logic [ADDR_W-1:0] hold_i,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  ctr_op_e           op;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    op = decode_op(load_p_i, up_p_i, dn_p_i);
    unique case (op)
      OP_LOAD: cnt_d = hold_i;
      OP_INC:  cnt_d = cnt_q + ONE;  // wraps naturally
      OP_DEC:  cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ser_addr_ctr.sv
module ser_addr_ctr
  import addr_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic              load_ni,
  input  logic              up_ni,
  input  logic              down_ni,
  output logic [ADDR_W-1:0] addr_o
);
  logic [N_STROBE-1:0] raw, pulse;
  logic                shift_p, latch_p, load_p, up_p, dn_p;
  logic [ADDR_W-1:0]   shift_q, hold_q;

  always_comb begin
    raw            = '0;
    raw[IDX_SCLK]  = sclk_i;
    raw[IDX_LATCH] = latch_i;
    raw[IDX_LOAD]  = load_ni;
    raw[IDX_UP]    = up_ni;
    raw[IDX_DN]    = down_ni;
  end

  strobe_sync #(
    .N      (N_STROBE),
    .STAGES (STAGES),
    .ACT_LOW(STROBE_ACT_LOW)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .pulse_o(pulse)
  );

  assign shift_p = pulse[IDX_SCLK];
  assign latch_p = pulse[IDX_LATCH];
  assign load_p  = pulse[IDX_LOAD];
  assign up_p    = pulse[IDX_UP];
  assign dn_p    = pulse[IDX_DN];

  ser_shift_hold #(
    .ADDR_W(ADDR_W),
    .STAGES(STAGES)
  ) sh_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .shift_p_i(shift_p),
    .latch_p_i(latch_p),
    .shift_o  (shift_q),
    .hold_o   (hold_q)
  );

  addr_updown #(
    .ADDR_W(ADDR_W)
  ) ctr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_p_i(load_p),
    .up_p_i  (up_p),
    .dn_p_i  (dn_p),
    .hold_i  (hold_q),
    .cnt_o   (addr_o)
  );
endmodule

// File: rtl/ser_addr_ctr_chk.sv
module ser_addr_ctr_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] shift_q,
  input logic [ADDR_W-1:0] hold_q,
  input logic              latch_p,
  input logic              load_p,
  input logic              up_p,
  input logic              dn_p
);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && hold_q == '0 && shift_q == '0));

  p_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_p |=> hold_q == $past(shift_q));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_p |=> $stable(hold_q));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_p |=> addr_o == $past(hold_q));

  p_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_p && up_p && !dn_p) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  p_one_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_p |=> !up_p);

  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_p && dn_p && !up_p) |=> addr_o == ADDR_W'($past(addr_o) - 1'b1));

  p_cancel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_p && up_p && dn_p) |=> $stable(addr_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_p && !up_p && !dn_p) |=> $stable(addr_o));
endmodule

bind ser_addr_ctr ser_addr_ctr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .shift_q(shift_q),
  .hold_q (hold_q),
  .latch_p(latch_p),
  .load_p (load_p),
  .up_p   (up_p),
  .dn_p   (dn_p)
);

// File: tb/ser_addr_ctr_tb_top.sv
module ser_addr_ctr_tb_top;
  localparam int W = 24;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, latch = 1'b0;
  logic load_n = 1'b1, up_n = 1'b1, down_n = 1'b1;
  logic [W-1:0] addr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_addr_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .sclk_i(sclk),
    .latch_i(latch), .load_ni(load_n), .up_ni(up_n), .down_ni(down_n),
    .addr_o(addr)
  );

  // reference model: a strobe acts at the third clock edge after it changes
  logic [5:0] hist [$];  // {down,up,load,latch,sclk,sdata}
  logic [W-1:0] m_sh, m_hold, m_cnt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {6'b111000, 6'b111000, 6'b111000, 6'b111000};
      m_sh = '0; m_hold = '0; m_cnt = '0;
    end else begin
      logic [5:0] a, b;
      bit ld, u, d;
      hist.push_front({down_n, up_n, load_n, latch, sclk, sdata});
      void'(hist.pop_back());
      a = hist[2]; b = hist[3];
      ld = !a[3] && b[3];
      u  = !a[4] && b[4];
      d  = !a[5] && b[5];
      if (ld) m_cnt = m_hold;
      else if (u && !d) m_cnt = (m_cnt + 1) & MASK;
      else if (d && !u) m_cnt = (m_cnt - 1) & MASK;
      if (a[2] && !b[2]) m_hold = m_sh;
      if (a[1] && !b[1]) m_sh = {m_sh[W-2:0], a[0]};
    end
  end

  // R4: every-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_ni && !done) begin
      checks++;
      if (addr !== m_cnt) begin
        fails++;
        $display("FAIL R4 model compare: addr=%06h expected=%06h", addr, m_cnt);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: addr=%06h expected=%06h", req, addr, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i]; idle(1);
      sclk = 1'b1; idle(4);
      sclk = 1'b0; idle(4);
    end
  endtask

  task automatic do_latch();
    latch = 1'b1; idle(4); latch = 1'b0; idle(4);
  endtask

  task automatic do_load();
    load_n = 1'b0; idle(4); load_n = 1'b1; idle(4);
  endtask

  task automatic do_up(int len);
    up_n = 1'b0; idle(len); up_n = 1'b1; idle(4);
  endtask

  task automatic do_down();
    down_n = 1'b0; idle(4); down_n = 1'b1; idle(4);
  endtask

  task automatic load_word(logic [W-1:0] v);
    send_bits(32'(v), W); do_latch(); do_load();
  endtask

  initial begin
    idle(3);
    check("R1 reset", '0);
    rst_ni = 1'b1;
    idle(5);
    check("R1 after reset", '0);

    send_bits(32'h123456, W);
    check("R3 no change before latch", '0);
    do_latch();
    check("R3 no change before load", '0);
    do_load();
    check("R2 R4 loaded word", 24'h123456);

    do_up(4);
    check("R5 increment", 24'h123457);
    do_up(30);
    check("R5 long pulse steps once", 24'h123458);
    do_down();
    check("R6 decrement", 24'h123457);

    load_word(24'hFFFFFF);
    check("R4 load all ones", 24'hFFFFFF);
    do_up(4);
    check("R7 wrap up", 24'h000000);
    do_down();
    check("R7 wrap down", 24'hFFFFFF);

    load_word(24'hA5C381);
    check("R2 msb first pattern", 24'hA5C381);
    do_up(4);
    send_bits(32'h00BEEF, W);
    do_latch();
    load_n = 1'b0; up_n = 1'b0; idle(4);
    load_n = 1'b1; up_n = 1'b1; idle(4);
    check("R8 load beats up", 24'h00BEEF);
    down_n = 1'b0; load_n = 1'b0; idle(4);
    down_n = 1'b1; load_n = 1'b1; idle(4);
    check("R8 load beats down", 24'h00BEEF);

    up_n = 1'b0; down_n = 1'b0; idle(4);
    up_n = 1'b1; down_n = 1'b1; idle(4);
    check("R9 up and down cancel", 24'h00BEEF);

    do_up(4);
    send_bits(32'h777777, W);
    do_load();
    check("R10 reload without latch keeps old word", 24'h00BEEF);

    send_bits(32'hF0_0F1E2D, 32);
    do_latch(); do_load();
    check("R11 last 24 bits kept", 24'h0F1E2D);

    idle(10);
    check("R10 idle strobes no effect", 24'h0F1E2D);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule